// File: doc/BRIEF.md
# Bus lock and hold arbiter

This block decides who owns the local bus around locked instruction sequences and the halted state of a processor core. A strobe from the decoder marks a lock prefix. From the next clock, an active-low lock output tells other bus masters that the core needs several bus cycles in a row. The lock stays asserted through the next instruction. It is dropped once the last bus cycle of that instruction has completed.

An external master asks for the bus with a level hold request. With no lock active, the request is granted when the current bus cycle completes, or on the next clock if the bus is idle. A request that arrives while the lock is asserted is recorded in a single pending bit. It is granted on the same clock that the lock is released. The grant follows the request down one clock after the request is removed.

A halt-entry strobe puts the block in the halted state and sends a one-clock halt status pulse. A hold granted while halted leaves the halted state in place. When that hold ends, the halt status pulse is sent again so that the system can latch the status a second time. Only the wake input (an interrupt request) or reset ends the halted state.

Top module: `bus_own_arbiter`

## Requirements
- R1: When the lock is released and no hold is granted, a high `lock_pfx_i` in one clock makes `lock_no` low after the next rising edge. A prefix strobe while `hold_gnt_o` is high has no effect.
- R2: The lock is released by the first clock, at or after a high `instr_end_i`, in which `cyc_done_i` is high or `bus_busy_i` is low. `lock_no` returns high after that edge. A `cyc_done_i` strobe before `instr_end_i` does not release the lock.
- R3: While `lock_no` is low, `hold_gnt_o` stays low whatever `hold_req_i` does.
- R4: A hold request seen while locked is recorded in a pending bit. The pending bit causes `hold_gnt_o` to rise on the same edge that `lock_no` returns high, even if the request has since been dropped. The pending bit clears when the grant is issued.
- R5: With no lock, a high `hold_req_i` is granted on the edge after a clock in which `cyc_done_i` is high or `bus_busy_i` is low. Otherwise the request waits.
- R6: While granted, `hold_gnt_o` stays high as long as `hold_req_i` is high. It falls on the edge after a clock with `hold_req_i` low.
- R7: A `halt_enter_i` strobe while not halted sets `halted_o` and produces a single-clock `halt_status_o` pulse after the next edge. A strobe while already halted produces no pulse.
- R8: A hold request while halted is granted, and `halted_o` stays high through the whole hold.
- R9: When `hold_gnt_o` falls while halted (and `wake_i` is low), `halt_status_o` pulses for one clock, starting on that same edge.
- R10: A high `wake_i` clears `halted_o` after the next edge. `wake_i` while not halted has no effect.
- R11: After reset `lock_no` is high and `hold_gnt_o`, `halted_o` and `halt_status_o` are low. Reset also clears lock and halt state held at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_pfx_i | input | 1 | Lock prefix decoded strobe |
| instr_end_i | input | 1 | End of the locked instruction strobe |
| cyc_done_i | input | 1 | Current bus cycle completes in this clock |
| bus_busy_i | input | 1 | A bus cycle is in progress |
| halt_enter_i | input | 1 | Halt instruction executed strobe |
| wake_i | input | 1 | Interrupt request that ends halt |
| hold_req_i | input | 1 | External hold request, level |
| lock_no | output | 1 | Bus lock, active low |
| hold_gnt_o | output | 1 | Hold granted to external master |
| halted_o | output | 1 | Halted state |
| halt_status_o | output | 1 | One-clock halt status announcement |

## Verification
The bench drives a stray `cyc_done_i` strobe before the end of the locked instruction. A design that releases on any completion would raise `lock_no` early. It raises and drops a request while locked and expects a grant on release anyway, which catches a pending bit that follows the request level. In the halted state it takes a hold and releases it, checking that `halted_o` survives and that the status pulse reappears exactly on the grant's falling edge. A design that sends no second pulse, or that wakes on the hold, shows up there. It also pulses a prefix under an active grant and asserts reset while locked and halted, so a lock taken under a grant or a state that outlives reset is reported.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    LK_OFF  = 2'd0,
    LK_ON   = 2'd1,
    LK_TAIL = 2'd2
  } lock_state_e;

endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import bus_own_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_pfx_i,
  input  logic instr_end_i,
  input  logic cyc_done_i,
  input  logic bus_busy_i,
  input  logic gnt_i,
  output logic active_o,
  output logic release_o
);

  lock_state_e state_q, state_d;
  logic        drain_ok;

  // last bus cycle finished, or nothing outstanding
  assign drain_ok = cyc_done_i | ~bus_busy_i;

  always_comb begin
    state_d   = state_q;
    release_o = 1'b0;
    unique case (state_q)
      LK_OFF: if (lock_pfx_i && !gnt_i) state_d = LK_ON;
      LK_ON: begin
        if (instr_end_i) begin
          if (drain_ok) begin
            state_d   = LK_OFF;
            release_o = 1'b1;
          end else begin
            state_d = LK_TAIL;
          end
        end
      end
      LK_TAIL: begin
        if (drain_ok) begin
          state_d   = LK_OFF;
          release_o = 1'b1;
        end
      end
      default: state_d = LK_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_OFF;
    else         state_q <= state_d;
  end

  assign active_o = (state_q != LK_OFF);

  assert_lock_after_prefix_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && lock_pfx_i && !gnt_i) |=> active_o);

  assert_lock_held_until_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_ON && !instr_end_i) |=> active_o);

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic lock_pfx_i,
  input  logic cyc_done_i,
  input  logic bus_busy_i,
  input  logic lock_active_i,
  input  logic lock_release_i,
  output logic gnt_o
);

  logic gnt_q, gnt_d;
  logic pend_q, pend_d;
  logic free_grant, rel_grant;

  assign free_grant = hold_req_i & ~lock_active_i & ~lock_pfx_i
                    & (cyc_done_i | ~bus_busy_i);
  assign rel_grant  = lock_release_i & (pend_q | hold_req_i);

  always_comb begin
    if (gnt_q) gnt_d = hold_req_i;
    else       gnt_d = free_grant | rel_grant;

    pend_d = pend_q;
    if (gnt_d && !gnt_q)                          pend_d = 1'b0;
    else if (hold_req_i && lock_active_i && !gnt_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      pend_q <= pend_d;
    end
  end

  assign gnt_o = gnt_q;

  assert_no_grant_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_active_i |-> !gnt_q);

  assert_pend_clear_on_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q |-> !pend_q);

  assert_grant_follows_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q && !hold_req_i) |=> !gnt_q);

endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_enter_i,
  input  logic wake_i,
  input  logic gnt_i,
  input  logic hold_req_i,
  output logic halted_o,
  output logic status_o
);

  logic halted_q, stat_q;
  logic enter_evt, rehalt_evt;

  assign enter_evt  = halt_enter_i & ~halted_q;
  // hold ends while halted: announce halt again
  assign rehalt_evt = halted_q & gnt_i & ~hold_req_i & ~wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      if (wake_i)         halted_q <= 1'b0;
      else if (enter_evt) halted_q <= 1'b1;
      stat_q <= (enter_evt & ~wake_i) | rehalt_evt;
    end
  end

  assign halted_o = halted_q;
  assign status_o = stat_q;

  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !wake_i) |=> halted_q);

  assert_wake_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !halted_q);

endmodule

// File: rtl/bus_own_arbiter.sv
module bus_own_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_pfx_i,
  input  logic instr_end_i,
  input  logic cyc_done_i,
  input  logic bus_busy_i,
  input  logic halt_enter_i,
  input  logic wake_i,
  input  logic hold_req_i,
  output logic lock_no,
  output logic hold_gnt_o,
  output logic halted_o,
  output logic halt_status_o
);

  logic lock_active, lock_release, gnt;

  lock_ctrl u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_pfx_i  (lock_pfx_i),
    .instr_end_i (instr_end_i),
    .cyc_done_i  (cyc_done_i),
    .bus_busy_i  (bus_busy_i),
    .gnt_i       (gnt),
    .active_o    (lock_active),
    .release_o   (lock_release)
  );

  hold_ctrl u_hold (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hold_req_i     (hold_req_i),
    .lock_pfx_i     (lock_pfx_i),
    .cyc_done_i     (cyc_done_i),
    .bus_busy_i     (bus_busy_i),
    .lock_active_i  (lock_active),
    .lock_release_i (lock_release),
    .gnt_o          (gnt)
  );

  halt_ctrl u_halt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_enter_i (halt_enter_i),
    .wake_i       (wake_i),
    .gnt_i        (gnt),
    .hold_req_i   (hold_req_i),
    .halted_o     (halted_o),
    .status_o     (halt_status_o)
  );

  assign lock_no    = ~lock_active;
  assign hold_gnt_o = gnt;

  assert_rehalt_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && hold_gnt_o && !hold_req_i && !wake_i) |=> (halt_status_o && !hold_gnt_o));

  assert_reset_state_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (lock_no && !hold_gnt_o && !halted_o && !halt_status_o));

endmodule

// File: tb/bus_own_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_own_arbiter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfx, iend, done, busy, hlt, wake, req;
  logic lock_n, gnt, halted, stat;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_own_arbiter dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .lock_pfx_i    (pfx),
    .instr_end_i   (iend),
    .cyc_done_i    (done),
    .bus_busy_i    (busy),
    .halt_enter_i  (hlt),
    .wake_i        (wake),
    .hold_req_i    (req),
    .lock_no       (lock_n),
    .hold_gnt_o    (gnt),
    .halted_o      (halted),
    .halt_status_o (stat)
  );

  // stim = {pfx,iend,done,busy,halt,wake,req}; expect = {lock_n,gnt,halted,stat}
  typedef struct packed {
    logic [6:0] stim;
    logic [3:0] expect_v;
    logic [7:0] rq;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VEC [0:NVEC-1] = '{
    '{7'b0001001, 4'b1000, 8'd5},   // R5 busy, no completion: wait
    '{7'b0011001, 4'b1100, 8'd5},   // R5 completion grants
    '{7'b0000001, 4'b1100, 8'd6},   // R6 held while requested
    '{7'b0000000, 4'b1000, 8'd6},   // R6 drop
    '{7'b0000001, 4'b1100, 8'd5},   // R5 idle bus grants
    '{7'b0000000, 4'b1000, 8'd6},
    '{7'b1001000, 4'b0000, 8'd1},   // R1 prefix locks
    '{7'b0001001, 4'b0000, 8'd3},   // R3 request while locked
    '{7'b0011001, 4'b0000, 8'd2},   // R2 stray completion keeps lock
    '{7'b0101001, 4'b0000, 8'd2},   // R2 end, cycle outstanding
    '{7'b0001001, 4'b0000, 8'd3},   // R3 still locked
    '{7'b0011001, 4'b1100, 8'd4},   // R4 release plus grant
    '{7'b0000000, 4'b1000, 8'd6},
    '{7'b1000000, 4'b0000, 8'd1},   // R1
    '{7'b0001001, 4'b0000, 8'd4},   // R4 request recorded
    '{7'b0001000, 4'b0000, 8'd4},   // R4 request dropped
    '{7'b0111000, 4'b1100, 8'd4},   // R4 pending granted at release
    '{7'b0000000, 4'b1000, 8'd6},
    '{7'b1000000, 4'b0000, 8'd1},   // R1
    '{7'b0100000, 4'b1000, 8'd2},   // R2 idle bus at end releases
    '{7'b0000100, 4'b1011, 8'd7},   // R7 halt entry pulse
    '{7'b0000000, 4'b1010, 8'd7},   // R7 pulse is one clock
    '{7'b0000001, 4'b1110, 8'd8},   // R8 hold in halt
    '{7'b0000001, 4'b1110, 8'd8},   // R8 still halted
    '{7'b0000000, 4'b1011, 8'd9},   // R9 re-announce on grant fall
    '{7'b0000000, 4'b1010, 8'd9},
    '{7'b0000100, 4'b1010, 8'd7},   // R7 no pulse when already halted
    '{7'b0000010, 4'b1000, 8'd10},  // R10 wake
    '{7'b0000010, 4'b1000, 8'd10}   // R10 wake when not halted
  };

  task automatic drive(input logic [6:0] s);
    {pfx, iend, done, busy, hlt, wake, req} = s;
  endtask

  task automatic check(input logic [3:0] e, input int rq);
    n_chk++;
    if ({lock_n, gnt, halted, stat} !== e) begin
      n_bad++;
      $display("FAIL R%0d: got %b expected %b", rq, {lock_n, gnt, halted, stat}, e);
    end
  endtask

  task automatic step(input logic [6:0] s, input logic [3:0] e, input int rq);
    drive(s);
    @(negedge clk);
    check(e, rq);
  endtask

  initial begin
    drive(7'b0);
    repeat (3) @(negedge clk);
    check(4'b1000, 11);            // R11 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(4'b1000, 11);            // R11 after release

    for (int i = 0; i < NVEC; i++)
      step(VEC[i].stim, VEC[i].expect_v, int'(VEC[i].rq));

    // R1: prefix under an active grant is ignored
    step(7'b0000001, 4'b1100, 5);
    step(7'b1000001, 4'b1100, 1);
    step(7'b0000000, 4'b1000, 1);
    step(7'b0000000, 4'b1000, 1);

    // R11: reset clears lock and halt
    step(7'b1000100, 4'b0011, 1);
    drive(7'b0);
    #1 rst_n = 1'b0;
    #1 check(4'b1000, 11);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(4'b1000, 11);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule